// File: doc/BRIEF.md
# Multiplexed external memory bus controller

This block sits between an 8-bit microcontroller core and the pins of its external memory bus. The core presents one access at a time: a program fetch, a data read or a data write, each with a 16-bit address. The block decides whether a fetch is served from on-chip ROM or from the bus, and for bus accesses it runs a fixed six-clock slot. During the slot it drives the high address byte on its own port and shares one byte-wide port between the low address and the data. A latch strobe lets external logic capture the low address before the shared port turns to data, and a separate active-low strobe is used for program reads, data reads and data writes.

Time is divided into slots of six oscillator clocks, two slots to a machine cycle. The latch strobe pulses in the first two clocks of every slot, whether or not the slot carries an access. The core offers a request on the last clock of a slot and the request runs in the next slot. Its response appears on the first clock of the slot that follows. An external-access input selects where low program addresses come from: when it is high, fetches at 0FFFH and below are internal and leave the bus idle, and when it is low, every fetch goes to the bus. Data reads and data writes always use the bus.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: While reset is held, `ale` is 0, `psen_n`, `rd_n` and `wr_n` are 1, `ad_oe`, `addr_hi_oe`, `port_claim` and `rsp_valid` are 0, and `req_ready` is 1.
- R2: `ale` is 1 in slot clocks 0 and 1 and 0 in clocks 2 to 5 of every six-clock slot, including idle slots, starting with the first clock after reset is released.
- R3: A request is taken on a clock edge where `req_ready` and `req_valid` are both 1. `req_ready` is 1 only in slot clock 5. The access occupies the following slot, and `rsp_valid` is 1 for exactly one clock, which is clock 0 of the slot after that.
- R4: In an external slot, `ad_oe` is 1 and `ad_out` equals address bits 7:0 in clocks 0 to 2, so the value is held across the falling edge of `ale`. `addr_hi_oe` is 1 and `addr_hi` equals address bits 15:8 for all six clocks.
- R5: The kind encoding is 00 program fetch, 01 data read, 10 data write and 11 no access. With `ext_access` at 1, a fetch at an address of 0FFFH or below is internal. An internal fetch produces no strobe, no port drive and no claim, and it answers with `rsp_external`=0 and `rsp_data`=0. A fetch at 1000H or above goes to the bus.
- R6: With `ext_access` at 0, every fetch goes to the bus, including fetches at 0000H to 0FFFH.
- R7: In an external fetch, `psen_n` is 0 in clocks 3 to 5 and `ad_oe` is 0 in those clocks. The response carries `rsp_external`=1 and `rsp_data` equal to `ad_in` as sampled at the clock edge that ends slot clock 5, which is the edge where `psen_n` rises.
- R8: A data read always uses the bus, whatever the address or `ext_access`. `rd_n` is 0 in clocks 3 to 5, the shared port is released, and the response data is sampled as in R7.
- R9: In a data write, `wr_n` is 0 in clocks 3 to 5. Write data is on `ad_out` with `ad_oe`=1 in exactly those clocks. The response has `rsp_external`=1 and `rsp_data`=0.
- R10: A request of kind 11 is ignored. Its slot has no strobe and no claim, and no `rsp_valid` follows it.
- R11: `port_claim` is 1 for all six clocks of an external slot and 0 otherwise. In slots without a bus access, `ad_oe` and `addr_hi_oe` are 0.
- R12: At most one of `psen_n`, `rd_n` and `wr_n` is 0 in any clock, and none of them is 0 while `ale` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_access | input | 1 | 1: low program addresses are internal; 0: all fetches external |
| req_valid | input | 1 | Core offers an access |
| req_kind | input | 2 | 00 fetch, 01 data read, 10 data write, 11 none |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Request is taken at this clock edge if valid |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_data | output | 8 | Read or fetch data, 0 for writes and internal fetches |
| rsp_external | output | 1 | Access ran on the external bus |
| ad_out | output | 8 | Shared low address / data output |
| ad_oe | output | 1 | Drive enable for the shared port |
| ad_in | input | 8 | Shared port input |
| addr_hi | output | 8 | High address byte |
| addr_hi_oe | output | 1 | Drive enable for the high address port |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| port_claim | output | 1 | Both address ports are owned by the bus; general I/O must yield |

## Verification
Each of the four access kinds is run for both values of `ext_access` over a set of addresses. The addresses include 0000H, the two addresses on each side of the 0FFFH/1000H boundary, a mid-range value and FFFFH, so an off-by-one in the boundary compare or an inverted `ext_access` sense shows up as a claim or strobe in the wrong slot. Every clock of every slot is compared with the expected strobe, enable and address values, which separates the address phase from the data phase and tells one strobe apart from another. The returned data is made from the address, so a sample taken at the wrong clock, or a read from the wrong kind, produces a wrong value. An idle stretch after reset confirms that the latch strobe keeps its rhythm when there is no traffic.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int HW = AW - DW;

  typedef enum logic [1:0] {
    K_FETCH  = 2'b00,
    K_DREAD  = 2'b01,
    K_DWRITE = 2'b10,
    K_NONE   = 2'b11
  } xkind_e;

  typedef struct packed {
    logic          valid;
    logic          ext;
    xkind_e        kind;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
  } xacc_t;

  // Decide whether an access uses the external bus.
  function automatic logic goes_external(input xkind_e k, input logic [AW-1:0] a,
                                         input logic ea, input logic [AW-1:0] int_top);
    case (k)
      K_FETCH:  goes_external = !(ea && (a <= int_top));
      K_DREAD,
      K_DWRITE: goes_external = 1'b1;
      default:  goes_external = 1'b0;
    endcase
  endfunction

  // Low and high address bytes.
  function automatic logic [DW-1:0] lo_byte(input logic [AW-1:0] a);
    lo_byte = a[DW-1:0];
  endfunction

  function automatic logic [HW-1:0] hi_byte(input logic [AW-1:0] a);
    hi_byte = a[AW-1:DW];
  endfunction
endpackage

// File: rtl/xbus_phase_gen.sv
module xbus_phase_gen #(
  parameter int SLOT_LEN = 6,
  parameter int ALE_LEN  = 2,
  localparam int PW      = $clog2(SLOT_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] phase,
  output logic          slot_end,
  output logic          ale
);
  localparam logic [PW-1:0] LAST    = PW'(SLOT_LEN - 1);
  localparam logic [PW-1:0] ALE_END = PW'(ALE_LEN);

  logic [PW-1:0] ph_q;

  // Reset parks the counter on the last phase so the latch strobe stays low.
  always_ff @(posedge clk) begin
    if (!rst_n)          ph_q <= LAST;
    else if (ph_q == LAST) ph_q <= '0;
    else                 ph_q <= ph_q + 1'b1;
  end

  assign phase    = ph_q;
  assign slot_end = (ph_q == LAST);
  assign ale      = (ph_q < ALE_END);
endmodule

// File: rtl/xbus_req_latch.sv
module xbus_req_latch
  import xbus_pkg::*;
#(
  parameter logic [AW-1:0] INT_TOP = 16'h0FFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_end,
  input  logic          ext_access,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output xacc_t         cur
);
  xacc_t  cur_q;
  xkind_e k_in;

  assign k_in = xkind_e'(req_kind);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else if (slot_end) begin
      cur_q.valid <= req_valid && (k_in != K_NONE);
      cur_q.ext   <= req_valid && goes_external(k_in, req_addr, ext_access, INT_TOP);
      cur_q.kind  <= k_in;
      cur_q.addr  <= req_addr;
      cur_q.wdata <= req_wdata;
    end
  end

  assign cur = cur_q;
endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
  import xbus_pkg::*;
#(
  parameter int SLOT_LEN  = 6,
  parameter int STB_START = 3,
  localparam int PW       = $clog2(SLOT_LEN)
) (
  input  logic [PW-1:0] phase,
  input  xacc_t         cur,
  output logic          addr_phase,
  output logic          bus_slot,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [HW-1:0] addr_hi,
  output logic          addr_hi_oe,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n
);
  localparam logic [PW-1:0] STB_PH = PW'(STB_START);

  logic data_phase;

  assign bus_slot   = cur.valid && cur.ext;
  assign addr_phase = bus_slot && (phase < STB_PH);
  assign data_phase = bus_slot && !(phase < STB_PH);

  assign psen_n = !(data_phase && cur.kind == K_FETCH);
  assign rd_n   = !(data_phase && cur.kind == K_DREAD);
  assign wr_n   = !(data_phase && cur.kind == K_DWRITE);

  // Write data only while the write strobe is active; reads leave the port floating.
  assign ad_oe  = addr_phase || (data_phase && cur.kind == K_DWRITE);
  assign ad_out = addr_phase ? lo_byte(cur.addr) : (ad_oe ? cur.wdata : '0);

  assign addr_hi_oe = bus_slot;
  assign addr_hi    = bus_slot ? hi_byte(cur.addr) : '0;
endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl
  import xbus_pkg::*;
#(
  parameter int            SLOT_LEN  = 6,
  parameter int            ALE_LEN   = 2,
  parameter int            ADDR_HOLD = 1,
  parameter logic [15:0]   INT_TOP   = 16'h0FFF,
  localparam int           STB_START = ALE_LEN + ADDR_HOLD,
  localparam int           PW        = $clog2(SLOT_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_access,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [15:0]   req_addr,
  input  logic [7:0]    req_wdata,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [7:0]    rsp_data,
  output logic          rsp_external,
  output logic [7:0]    ad_out,
  output logic          ad_oe,
  input  logic [7:0]    ad_in,
  output logic [7:0]    addr_hi,
  output logic          addr_hi_oe,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic          port_claim
);
  logic [PW-1:0] phase;
  logic          slot_end;
  logic          addr_phase;
  logic          bus_slot;
  xacc_t         cur;

  xbus_phase_gen #(.SLOT_LEN(SLOT_LEN), .ALE_LEN(ALE_LEN)) u_phase (
    .clk(clk), .rst_n(rst_n), .phase(phase), .slot_end(slot_end), .ale(ale)
  );

  xbus_req_latch #(.INT_TOP(INT_TOP)) u_req (
    .clk(clk), .rst_n(rst_n), .slot_end(slot_end), .ext_access(ext_access),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .req_wdata(req_wdata), .cur(cur)
  );

  xbus_strobe_gen #(.SLOT_LEN(SLOT_LEN), .STB_START(STB_START)) u_stb (
    .phase(phase), .cur(cur), .addr_phase(addr_phase), .bus_slot(bus_slot),
    .ad_out(ad_out), .ad_oe(ad_oe), .addr_hi(addr_hi), .addr_hi_oe(addr_hi_oe),
    .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  assign req_ready  = slot_end;
  assign port_claim = bus_slot;

  // Read data is sampled on the edge where the read strobe returns high.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_data     <= '0;
      rsp_external <= 1'b0;
    end else if (slot_end) begin
      rsp_valid    <= cur.valid;
      rsp_external <= cur.valid && cur.ext;
      rsp_data     <= (cur.valid && cur.ext && cur.kind != K_DWRITE) ? ad_in : '0;
    end else begin
      rsp_valid    <= 1'b0;
    end
  end
endmodule

// File: rtl/xbus_checks.sv
module xbus_checks #(
  parameter int SLOT_LEN = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ale,
  input logic       psen_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic       ad_oe,
  input logic [7:0] ad_out,
  input logic       addr_phase,
  input logic       port_claim,
  input logic       addr_hi_oe,
  input logic       rsp_valid,
  input logic       slot_end
);
  logic        ale_q;
  logic        seen_rise;
  logic [15:0] gap;
  logic        ale_rise;

  assign ale_rise = ale && !ale_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ale_q     <= 1'b0;
      seen_rise <= 1'b0;
      gap       <= '0;
    end else begin
      ale_q <= ale;
      if (ale_rise) begin
        seen_rise <= 1'b1;
        gap       <= '0;
      end else begin
        gap <= gap + 16'd1;
      end
    end
  end

  // R2: latch strobe keeps a fixed period
  p_ale_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_rise && seen_rise) |-> (gap == 16'(SLOT_LEN - 1)));

  // R12: strobes exclusive and never during the latch pulse
  p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!psen_n, !rd_n, !wr_n}) <= 1);
  p_no_strobe_in_ale_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (psen_n && rd_n && wr_n));

  // R7 / R8: read strobes leave the shared port floating
  p_read_floats_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !psen_n) |-> !ad_oe);

  // R9: data driven outside the address phase only under the write strobe
  p_wdata_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe && !addr_phase) |-> !wr_n);
  p_wr_drives_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);

  // R4: low address held across the falling edge of the latch strobe
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ale) && port_claim) |-> (ad_oe && $stable(ad_out)));

  // R11: idle slots release both ports and assert no strobe
  p_idle_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !port_claim |-> (!ad_oe && !addr_hi_oe && psen_n && rd_n && wr_n));

  // R3: response pulse follows a slot end
  p_rsp_timing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(slot_end));
endmodule

bind xmem_bus_ctrl xbus_checks #(.SLOT_LEN(SLOT_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
  .ad_oe(ad_oe), .ad_out(ad_out), .addr_phase(addr_phase), .port_claim(port_claim),
  .addr_hi_oe(addr_hi_oe), .rsp_valid(rsp_valid), .slot_end(slot_end)
);

// File: tb/sim_xmem_bus_ctrl.sv
module sim_xmem_bus_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_access = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'b00;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  ad_in = '0;
  logic        req_ready, rsp_valid, rsp_external, ad_oe, addr_hi_oe;
  logic        ale, psen_n, rd_n, wr_n, port_claim;
  logic [7:0]  rsp_data, ad_out, addr_hi;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  xmem_bus_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ext_access(ext_access), .req_valid(req_valid),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_external(rsp_external), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .addr_hi(addr_hi), .addr_hi_oe(addr_hi_oe), .ale(ale), .psen_n(psen_n),
    .rd_n(rd_n), .wr_n(wr_n), .port_claim(port_claim)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_val(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic bit on_bus(input logic [1:0] k, input logic [15:0] a, input logic ea);
    if (k == 2'b11) return 0;
    if (k == 2'b00 && ea && a < 16'h1000) return 0;
    return 1;
  endfunction

  task automatic run_access(input logic [1:0] k, input logic [15:0] a,
                            input logic ea, input logic [7:0] wd);
    bit ext;
    ext = on_bus(k, a, ea);
    do @(negedge clk); while (!req_ready);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd;
    ext_access = ea; ad_in = mem_val(a);
    for (int p = 0; p < 6; p++) begin
      @(negedge clk);
      if (p == 0) begin
        req_valid = 1'b0; ext_access = ~ea; req_addr = ~a;
      end
      chk("R2 ale", 16'(ale), 16'(p < 2));
      chk("R3 ready", 16'(req_ready), 16'(p == 5));
      chk("R11 claim", 16'(port_claim), 16'(ext));
      chk("R4 addr_hi_oe", 16'(addr_hi_oe), 16'(ext));
      if (ext) chk("R4 addr_hi", 16'(addr_hi), 16'(a[15:8]));
      chk("R7 psen_n", 16'(psen_n), 16'(!(ext && k == 2'b00 && p >= 3)));
      chk("R8 rd_n", 16'(rd_n), 16'(!(ext && k == 2'b01 && p >= 3)));
      chk("R9 wr_n", 16'(wr_n), 16'(!(ext && k == 2'b10 && p >= 3)));
      chk("R9 ad_oe", 16'(ad_oe), 16'(ext && (p < 3 || k == 2'b10)));
      if (ext && p < 3) chk("R4 ad_out addr", 16'(ad_out), 16'(a[7:0]));
      if (ext && p >= 3 && k == 2'b10) chk("R9 ad_out data", 16'(ad_out), 16'(wd));
      if (k == 2'b11) chk("R10 no rsp", 16'(rsp_valid), 16'd0);
    end
    @(negedge clk);
    chk("R3 rsp_valid", 16'(rsp_valid), 16'(k != 2'b11));
    if (k != 2'b11) begin
      chk("R5 rsp_external", 16'(rsp_external), 16'(ext));
      chk("R7 rsp_data", 16'(rsp_data), 16'((ext && k != 2'b10) ? mem_val(a) : 8'h00));
    end
    @(negedge clk);
    chk("R3 rsp one clock", 16'(rsp_valid), 16'd0);
  endtask

  initial begin
    logic [15:0] addrs [8];
    addrs = '{16'h0000, 16'h0ABC, 16'h0FFE, 16'h0FFF, 16'h1000, 16'h1001, 16'h8000, 16'hFFFF};
    repeat (3) @(negedge clk);
    chk("R1 ale", 16'(ale), 16'd0);
    chk("R1 strobes", 16'({psen_n, rd_n, wr_n}), 16'h7);
    chk("R1 oe", 16'({ad_oe, addr_hi_oe, port_claim, rsp_valid}), 16'h0);
    chk("R1 ready", 16'(req_ready), 16'd1);
    rst_n = 1'b1;
    for (int c = 0; c < 18; c++) begin
      @(negedge clk);
      chk("R2 ale idle", 16'(ale), 16'((c % 6) < 2));
      chk("R11 idle claim", 16'({port_claim, ad_oe, addr_hi_oe}), 16'h0);
      chk("R3 idle rsp", 16'(rsp_valid), 16'd0);
    end
    for (int ea = 0; ea < 2; ea++)
      for (int k = 0; k < 4; k++)
        for (int i = 0; i < 8; i++)
          run_access(2'(k), addrs[i], 1'(ea), 8'(8'hC3 ^ addrs[i][7:0] ^ 8'(k)));
    // R5 R6 boundary pair directly
    run_access(2'b00, 16'h0FFF, 1'b1, 8'h00);
    run_access(2'b00, 16'h0FFF, 1'b0, 8'h00);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule